// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Output Saturation

This block is the multiply-accumulate datapath of a 16-bit signal-processing core. Every valid operation multiplies two signed 16-bit operands in a single clock and writes the selected one of four 36-bit accumulators. The write is a plain product load, the accumulator plus the product, the accumulator minus the product, or a clear. Each accumulator holds four guard bits above a 32-bit body. Sums can therefore grow past the 32-bit range without losing their sign, and a saturating limiter catches that growth when the value is read out.

The operands are read either as integers or as signed fractions with the binary point after the sign bit. In fractional mode the product is doubled so that its binary point lines up with the accumulator's. The one product that cannot be represented, minus one times minus one, is pinned to the largest positive 32-bit value. The read port shows the accumulator that the select input currently names, both in full and through the limiter. A sticky flag records every write whose result would need limiting.

Top module: `fmac_unit`

## Requirements
- R1: A synchronous reset clears all four accumulators to zero and clears the sticky overflow flag.
- R2: With op_valid high and op = 2'b00, the selected accumulator is loaded with the product. In integer mode the product is the signed 16x16 product, sign-extended to 36 bits.
- R3: With op_valid high and op = 2'b01, the product is added to the selected accumulator, modulo 2^36.
- R4: With op_valid high and op = 2'b10, the product is subtracted from the selected accumulator, modulo 2^36.
- R5: With op_valid high and op = 2'b11, the selected accumulator is set to zero, whatever the operands are.
- R6: With frac_mode high, the signed product is shifted left by one bit before use. The single exception is 0x8000 times 0x8000, which gives 0x7FFFFFFF.
- R7: Only the accumulator named by acc_sel is written. While op_valid is low, no accumulator changes, whatever op, the operands and the mode are.
- R8: acc_out shows the full 36-bit accumulator named by acc_sel, without a clock of delay. A write becomes visible right after the clock edge that performs it.
- R9: When bits 35 down to 31 of the selected accumulator are all equal, lim_out equals bits 31..0 and lim_flag is low.
- R10: Otherwise lim_out is 0x7FFFFFFF if bit 35 is 0 and 0x80000000 if bit 35 is 1, and lim_flag is high.
- R11: ovf_sticky goes high after any valid write whose result would be limited under R10. It stays high until reset, and a clear operation does not lower it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Perform the operation in this cycle |
| op | input | 2 | 00 load, 01 add, 10 subtract, 11 clear |
| acc_sel | input | 2 | Accumulator to write and to read out |
| frac_mode | input | 1 | 1 = fractional product, 0 = integer product |
| a | input | 16 | Signed multiplicand |
| b | input | 16 | Signed multiplier |
| acc_out | output | 36 | Full contents of the selected accumulator |
| lim_out | output | 32 | Selected accumulator after the saturating limiter |
| lim_flag | output | 1 | lim_out is a clamped value |
| ovf_sticky | output | 1 | A write has produced a value needing limiting since reset |

## Verification
The bench uses the default parameters: 16-bit operands, four guard bits and four accumulators. All four accumulators can be addressed, so writes to one can be seen to leave its neighbours untouched. With only four guard bits, two accumulations of the largest fractional product already carry a value past 32 bits. This lets the limiter be driven into both clamps, and the sticky flag be set, within a handful of cycles. The corner product of minus one squared is reachable directly from the operand inputs.

// File: rtl/fmac_pkg.sv
`timescale 1ns/1ps
package fmac_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_CLR  = 2'b11
    } fmac_op_e;

endpackage

// File: rtl/fmac_mult.sv
`timescale 1ns/1ps
module fmac_mult #(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 4
) (
    input  logic [DATA_W-1:0]           a,
    input  logic [DATA_W-1:0]           b,
    input  logic                        frac_mode,
    output logic [2*DATA_W+GUARD_W-1:0] prod
);
    localparam int PROD_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] OPND_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [PROD_W-1:0] PROD_MAX = {1'b0, {(PROD_W-1){1'b1}}};

    logic signed [PROD_W-1:0] raw;
    logic        [PROD_W-1:0] scaled;
    logic                     corner;

    always_comb begin
        raw    = $signed(a) * $signed(b);
        corner = (a == OPND_MIN) && (b == OPND_MIN);
        if (!frac_mode) begin
            scaled = raw;
        end else if (corner) begin
            scaled = PROD_MAX;
        end else begin
            scaled = {raw[PROD_W-2:0], 1'b0};
        end
        prod = {{GUARD_W{scaled[PROD_W-1]}}, scaled};
    end

endmodule

// File: rtl/fmac_limit.sv
`timescale 1ns/1ps
module fmac_limit #(
    parameter int PROD_W  = 32,
    parameter int GUARD_W = 4
) (
    input  logic [PROD_W+GUARD_W-1:0] val,
    output logic [PROD_W-1:0]         lim,
    output logic                      hit
);
    localparam int ACC_W = PROD_W + GUARD_W;
    localparam logic [PROD_W-1:0] POS_SAT = {1'b0, {(PROD_W-1){1'b1}}};
    localparam logic [PROD_W-1:0] NEG_SAT = {1'b1, {(PROD_W-1){1'b0}}};

    logic [GUARD_W:0] top;

    always_comb begin
        top = val[ACC_W-1:PROD_W-1];
        hit = !((&top) || !(|top));
        if (!hit) begin
            lim = val[PROD_W-1:0];
        end else if (val[ACC_W-1]) begin
            lim = NEG_SAT;
        end else begin
            lim = POS_SAT;
        end
    end

endmodule

// File: rtl/fmac_unit.sv
`timescale 1ns/1ps
module fmac_unit #(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 4,
    parameter int NUM_ACC = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   op_valid,
    input  logic [1:0]                             op,
    input  logic [((NUM_ACC > 1) ? $clog2(NUM_ACC) : 1)-1:0] acc_sel,
    input  logic                                   frac_mode,
    input  logic [DATA_W-1:0]                      a,
    input  logic [DATA_W-1:0]                      b,
    output logic [2*DATA_W+GUARD_W-1:0]            acc_out,
    output logic [2*DATA_W-1:0]                    lim_out,
    output logic                                   lim_flag,
    output logic                                   ovf_sticky
);
    import fmac_pkg::*;

    localparam int PROD_W = 2 * DATA_W;
    localparam int ACC_W  = PROD_W + GUARD_W;
    localparam logic [PROD_W-1:0] POS_SAT = {1'b0, {(PROD_W-1){1'b1}}};
    localparam logic [PROD_W-1:0] NEG_SAT = {1'b1, {(PROD_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] OPND_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [NUM_ACC-1:0][ACC_W-1:0] acc;
        logic                          ovf;
    } state_t;

    state_t           state_d, state_q;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] cur_acc;
    logic [ACC_W-1:0] wr_val;
    logic [PROD_W-1:0] wr_lim;
    logic             wr_hit;

    fmac_mult #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_mult (
        .a         (a),
        .b         (b),
        .frac_mode (frac_mode),
        .prod      (prod)
    );

    // Limiter on the write path: decides whether the new value would clamp.
    fmac_limit #(.PROD_W(PROD_W), .GUARD_W(GUARD_W)) u_wr_limit (
        .val (wr_val),
        .lim (wr_lim),
        .hit (wr_hit)
    );

    // Limiter on the read path: drives the clamped output.
    fmac_limit #(.PROD_W(PROD_W), .GUARD_W(GUARD_W)) u_rd_limit (
        .val (cur_acc),
        .lim (lim_out),
        .hit (lim_flag)
    );

    always_comb begin
        cur_acc = state_q.acc[acc_sel];
        unique case (fmac_op_e'(op))
            OP_LOAD: wr_val = prod;
            OP_ADD:  wr_val = cur_acc + prod;
            OP_SUB:  wr_val = cur_acc - prod;
            default: wr_val = '0;
        endcase

        state_d = state_q;
        if (op_valid) begin
            state_d.acc[acc_sel] = wr_val;
            if (wr_hit) begin
                state_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_out    = cur_acc;
    assign ovf_sticky = state_q.ovf;

    // Assertions next to the datapath they guard.
    a_r2_load_takes_product : assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_LOAD) |=> state_q.acc[$past(acc_sel)] == $past(prod));

    a_r5_clear_zeroes : assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_CLR) |=> state_q.acc[$past(acc_sel)] == '0);

    a_r6_frac_corner : assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_LOAD && frac_mode && a == OPND_MIN && b == OPND_MIN)
        |=> state_q.acc[$past(acc_sel)] == {{GUARD_W{1'b0}}, POS_SAT});

    a_r7_idle_hold : assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(state_q.acc));

    a_r9_pass_through : assert property (@(posedge clk) disable iff (rst)
        !lim_flag |-> acc_out == {{GUARD_W{lim_out[PROD_W-1]}}, lim_out});

    a_r10_clamp_value : assert property (@(posedge clk) disable iff (rst)
        lim_flag |-> (lim_out == POS_SAT || lim_out == NEG_SAT));

    a_r11_sticky_holds : assert property (@(posedge clk) disable iff (rst)
        state_q.ovf |=> state_q.ovf);

endmodule

// File: tb/fmac_unit_bench.sv
`timescale 1ns/1ps
module fmac_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op;
    logic [1:0]  acc_sel;
    logic        frac_mode;
    logic [15:0] a, b;
    logic [35:0] acc_out;
    logic [31:0] lim_out;
    logic        lim_flag;
    logic        ovf_sticky;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [35:0] m_acc [4];
    logic        m_ovf;

    always #2.5 clk = ~clk;

    fmac_unit u_fmac_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .acc_sel(acc_sel),
        .frac_mode(frac_mode), .a(a), .b(b), .acc_out(acc_out),
        .lim_out(lim_out), .lim_flag(lim_flag), .ovf_sticky(ovf_sticky)
    );

    function automatic logic [35:0] ref_prod(input logic [15:0] x, input logic [15:0] y,
                                             input logic fr);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        if (fr) begin
            if (x == 16'h8000 && y == 16'h8000) p = 64'sh7FFFFFFF;
            else p = p * 2;
        end
        return p[35:0];
    endfunction

    function automatic logic [32:0] ref_limit(input logic [35:0] v);
        longint s;
        s = longint'($signed(v));
        if (s > 64'sd2147483647)       return {1'b1, 32'h7FFFFFFF};
        else if (s < -64'sd2147483648) return {1'b1, 32'h80000000};
        else                           return {1'b0, v[31:0]};
    endfunction

    task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_acc(input string tag, input int sel);
        logic [32:0] l;
        acc_sel = 2'(sel);
        #1;
        l = ref_limit(m_acc[sel]);
        check({tag, " acc_out"}, acc_out, m_acc[sel]);
        check({tag, " lim_out"}, {4'h0, lim_out}, {4'h0, l[31:0]});
        check({tag, " lim_flag"}, {35'h0, lim_flag}, {35'h0, l[32]});
    endtask

    task automatic check_ovf(input string tag);
        check({tag, " ovf_sticky"}, {35'h0, ovf_sticky}, {35'h0, m_ovf});
    endtask

    task automatic do_op(input logic [1:0] o, input int sel, input logic fr,
                         input logic [15:0] x, input logic [15:0] y);
        logic [35:0] p, nv;
        logic [32:0] l;
        @(negedge clk);
        op_valid = 1'b1; op = o; acc_sel = 2'(sel); frac_mode = fr; a = x; b = y;
        p = ref_prod(x, y, fr);
        case (o)
            2'b00:   nv = p;
            2'b01:   nv = m_acc[sel] + p;
            2'b10:   nv = m_acc[sel] - p;
            default: nv = '0;
        endcase
        @(posedge clk);
        m_acc[sel] = nv;
        l = ref_limit(nv);
        if (l[32]) m_ovf = 1'b1;
        #1;
        op_valid = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        m_ovf = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) check_acc("R1 reset", i);
        check_ovf("R1 reset");
    endtask

    task automatic t_int_ops();
        do_op(2'b00, 1, 1'b0, 16'd100, 16'd200);
        check_acc("R2 int load", 1);
        check_acc("R8 readout", 1);
        do_op(2'b01, 1, 1'b0, -16'sd300, 16'd7);
        check_acc("R3 int add", 1);
        do_op(2'b10, 1, 1'b0, 16'h8000, 16'h8000);
        check_acc("R4 int sub", 1);
        do_op(2'b00, 0, 1'b0, 16'd3, -16'sd5);
        check_acc("R2 negative load", 0);
        check_ovf("R11 no overflow yet");
    endtask

    task automatic t_frac();
        do_op(2'b00, 2, 1'b1, 16'h4000, 16'h4000);
        check_acc("R6 frac half squared", 2);
        do_op(2'b01, 2, 1'b1, 16'hC000, 16'h2000);
        check_acc("R6 frac add", 2);
        do_op(2'b00, 3, 1'b1, 16'h8000, 16'h8000);
        check_acc("R6 frac corner", 3);
        check_ovf("R6 corner no overflow");
    endtask

    task automatic t_isolation();
        do_op(2'b00, 2, 1'b0, 16'd1234, 16'd3);
        check_acc("R7 neighbour 0", 0);
        check_acc("R7 neighbour 1", 1);
        check_acc("R7 neighbour 3", 3);
        check_acc("R7 target", 2);
        @(negedge clk);
        op_valid = 1'b0; op = 2'b01; frac_mode = 1'b1; a = 16'h7FFF; b = 16'h7FFF;
        acc_sel = 2'd0;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) check_acc("R7 idle", i);
    endtask

    task automatic t_clear();
        do_op(2'b11, 1, 1'b1, 16'h7FFF, 16'h1234);
        check_acc("R5 clear", 1);
        check_acc("R5 untouched", 0);
    endtask

    task automatic t_limit();
        do_op(2'b01, 3, 1'b1, 16'h8000, 16'h8000);
        check_acc("R10 positive clamp", 3);
        check_ovf("R11 set");
        do_op(2'b10, 0, 1'b1, 16'h8000, 16'h8000);
        do_op(2'b10, 0, 1'b1, 16'h8000, 16'h8000);
        do_op(2'b10, 0, 1'b1, 16'h8000, 16'h8000);
        check_acc("R10 negative clamp", 0);
        do_op(2'b00, 1, 1'b1, 16'h7FFF, 16'h7FFF);
        check_acc("R9 in range", 1);
        do_op(2'b11, 3, 1'b0, 16'h0, 16'h0);
        check_acc("R5 clear after clamp", 3);
        check_ovf("R11 survives clear");
    endtask

    task automatic t_reset_again();
        apply_reset();
        t_reset();
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op = 2'b00; acc_sel = 2'd0;
        frac_mode = 1'b0; a = '0; b = '0;
        for (int i = 0; i < 4; i++) m_acc[i] = '0;
        m_ovf = 1'b0;
        apply_reset();
        t_reset();
        t_int_ops();
        t_frac();
        t_isolation();
        t_clear();
        t_limit();
        t_reset_again();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule